// File: doc/BRIEF.md
# Categorized Serial Configuration Loader

This block receives configuration words for an image-sensor timing generator over a three-wire serial port: a data line, a shift clock and an active-low strobe that frames each word. A word is 48 bits long. Its low byte must carry a fixed chip-select code and the next two bits select a category, so one serial line can feed a control register bank or a shutter register bank. Words with a wrong code, the wrong length or an unsupported category are dropped.

An accepted word is first held in a pending buffer. Each field then becomes live at the timing point its function needs. The shutter settings and most control settings take effect at the falling edge of the horizontal sync on the line that carries the readout pulses. Drive mode and the sync pattern selector take effect at the falling edge of vertical sync. The power state takes effect at the closing strobe edge. A freeze input from the shutter sequencer holds every pending commit back until it drops. All inputs are sampled in the system clock domain.

Top module: `serial_cfg_loader`

## Requirements
- R1: A data bit is shifted in on each rising edge of `sclk_i` while `sen_i` is low, and the first bit shifted is D00. At the rising edge of `sen_i` the word is examined only when exactly 48 bits were shifted in that strobe window. Shorter or longer words change no output.
- R2: A word is accepted only when D00 and D07 are 1 and D01 to D06 are 0. Any other code leaves every output and every pending value unchanged.
- R3: Category bits D09:D08 = 00 route the word to the control bank and 01 route it to the shutter bank. With D09 = 1 the word is ignored. A second word of the same category, sent before a commit, replaces the first one.
- R4: Control-bank fields: D12:D10 drive mode (D10 LSB), D13 shutter enable, D14 readout suppress, D17 pattern select, D32 wide clamp, D33 ID/EXP select, D35:D34 clamp pattern, D37:D36 ADC clock phase, D39:D38 power state. An accepted word changes no mode or bank output before its commit point.
- R5: The pending shutter enable, readout suppress, wide clamp, ID/EXP select, clamp pattern and ADC phase, and all pending shutter fields, become live on the cycle after a falling edge of `hd_i` sampled while `rdline_i` is high. A falling edge of `hd_i` while `rdline_i` is low commits nothing.
- R6: The pending drive mode and pattern select become live on the cycle after a falling edge of `vd_i`, and at no other time.
- R7: While `freeze_i` is high, sync edges commit nothing. Pending values are kept and are committed at the next sync edge that arrives with `freeze_i` low.
- R8: The power state D39:D38 of an accepted control word takes effect on the cycle after the `sen_i` rising edge. The encodings are 00 or 10 run, 01 sleep (`sleep_o` high) and 11 standby (`standby_o` high).
- R9: While in standby, an accepted control word changes only the power state, and a shutter word is ignored.
- R10: After reset every output is 0, except `adc_phase_o`, which is 01. The ADC phase codes 00, 01, 10 and 11 stand for 0, 90, 180 and 270 degrees.
- R11: Shutter-bank fields: D19:D10 vertical period count, D31:D20 horizontal period count, D41:D32 high-speed period position, each with its LSB at the lower bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdat_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock, data taken on its rising edge |
| sen_i | input | 1 | Serial strobe, low while a word is shifted in |
| hd_i | input | 1 | Horizontal sync |
| vd_i | input | 1 | Vertical sync |
| rdline_i | input | 1 | High during the line that carries readout pulses |
| freeze_i | input | 1 | Blocks all commits while high |
| drv_mode_o | output | 3 | Live drive mode |
| shut_en_o | output | 1 | Live shutter enable |
| rd_supp_o | output | 1 | Live readout suppress |
| pal_sel_o | output | 1 | Live sync pattern select |
| wide_ob_o | output | 1 | Live wide clamp enable |
| exp_sel_o | output | 1 | Live ID/EXP output select |
| ob_pat_o | output | 2 | Live clamp pattern |
| adc_phase_o | output | 2 | Live ADC clock phase |
| sleep_o | output | 1 | Sleep power state |
| standby_o | output | 1 | Standby power state |
| shut_vcnt_o | output | 10 | Live shutter vertical period count |
| shut_hcnt_o | output | 12 | Live shutter horizontal period count |
| shut_hpos_o | output | 10 | Live high-speed period position |

## Verification
The assertions assume that every serial and sync input is synchronous to `clk_i` and holds each level for at least one clock. Under that assumption an edge is the difference between two consecutive samples, and a change of a live output can be traced to the sync or strobe edge seen in the previous cycle. The bench drives every input on the falling clock edge and holds each level of `sclk_i`, `hd_i` and `vd_i` for at least one full period. It also leaves two idle clocks between events, so that a strobe edge and a sync edge never fall in the same cycle.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int CODE_LO = 0;
  localparam int CAT_LO  = 8;
  localparam int MODE_LO = 10;
  localparam int SHEN_B  = 13;
  localparam int RDS_B   = 14;
  localparam int PAL_B   = 17;
  localparam int WOB_B   = 32;
  localparam int EXP_B   = 33;
  localparam int OBP_LO  = 34;
  localparam int ADC_LO  = 36;
  localparam int PWR_LO  = 38;
  localparam int VCNT_LO = 10;
  localparam int HCNT_LO = 20;
  localparam int HPOS_LO = 32;
  localparam int LAST_USED = 41;

  typedef enum logic [1:0] {
    PWR_RUN0  = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_RUN1  = 2'b10,
    PWR_STBY  = 2'b11
  } pwr_t;

  typedef struct packed {
    logic       shen;
    logic       rds;
    logic       wob;
    logic       expsel;
    logic [1:0] obp;
    logic [1:0] adc;
  } hd_ctl_t;

  typedef struct packed {
    logic [2:0] mode;
    logic       pal;
  } vd_ctl_t;

  typedef struct packed {
    logic [9:0]  vcnt;
    logic [11:0] hcnt;
    logic [9:0]  hpos;
  } shut_t;

  localparam hd_ctl_t HD_CTL_RST = '{shen: 1'b0, rds: 1'b0, wob: 1'b0,
                                     expsel: 1'b0, obp: 2'b00, adc: 2'b01};
endpackage

// File: rtl/slr_edge_det.sv
module slr_edge_det #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_edge
      assign rise_o[i] = sig_i[i] & ~prev_q[i];
      assign fall_o[i] = ~sig_i[i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/slr_shift_rx.sv
module slr_shift_rx #(
  parameter int FRAME_W = 48,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               sen_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (sen_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      word_d = {din_i, word_q[FRAME_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word_o = word_q;
  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/slr_word_decode.sv
module slr_word_decode
  import slr_pkg::*;
#(
  parameter int               FRAME_W   = 48,
  parameter int               CODE_W    = 8,
  parameter logic [CODE_W-1:0] CHIP_CODE = 8'h81
) (
  input  logic [FRAME_W-1:0] word_i,
  output logic               is_ctl_o,
  output logic               is_shut_o,
  output hd_ctl_t            hd_o,
  output vd_ctl_t            vd_o,
  output shut_t              shut_o,
  output pwr_t               pwr_o
);
  logic       chip_ok;
  logic [1:0] cat;
  logic       unused_tail;

  assign chip_ok   = (word_i[CODE_LO +: CODE_W] == CHIP_CODE);
  assign cat       = word_i[CAT_LO +: 2];
  assign is_ctl_o  = chip_ok & (cat == 2'b00);
  assign is_shut_o = chip_ok & (cat == 2'b01);

  assign hd_o.shen   = word_i[SHEN_B];
  assign hd_o.rds    = word_i[RDS_B];
  assign hd_o.wob    = word_i[WOB_B];
  assign hd_o.expsel = word_i[EXP_B];
  assign hd_o.obp    = word_i[OBP_LO +: 2];
  assign hd_o.adc    = word_i[ADC_LO +: 2];
  assign vd_o.mode   = word_i[MODE_LO +: 3];
  assign vd_o.pal    = word_i[PAL_B];
  assign pwr_o       = pwr_t'(word_i[PWR_LO +: 2]);
  assign shut_o.vcnt = word_i[VCNT_LO +: 10];
  assign shut_o.hcnt = word_i[HCNT_LO +: 12];
  assign shut_o.hpos = word_i[HPOS_LO +: 10];

  assign unused_tail = ^word_i[FRAME_W-1:LAST_USED+1];
endmodule

// File: rtl/slr_reg_bank.sv
module slr_reg_bank
  import slr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acc_ctl_i,
  input  logic    acc_shut_i,
  input  hd_ctl_t hd_new_i,
  input  vd_ctl_t vd_new_i,
  input  shut_t   shut_new_i,
  input  pwr_t    pwr_new_i,
  input  logic    hd_commit_i,
  input  logic    vd_commit_i,
  output hd_ctl_t hd_live_o,
  output vd_ctl_t vd_live_o,
  output shut_t   shut_live_o,
  output pwr_t    pwr_o
);
  hd_ctl_t hd_pend_q, hd_pend_d, hd_live_q, hd_live_d;
  vd_ctl_t vd_pend_q, vd_pend_d, vd_live_q, vd_live_d;
  shut_t   sh_pend_q, sh_pend_d, sh_live_q, sh_live_d;
  logic    hd_v_q, hd_v_d, vd_v_q, vd_v_d, sh_v_q, sh_v_d;
  pwr_t    pwr_q, pwr_d;
  logic    in_stby, take_ctl, take_shut;

  assign in_stby   = (pwr_q == PWR_STBY);
  assign take_ctl  = acc_ctl_i & ~in_stby;
  assign take_shut = acc_shut_i & ~in_stby;

  always_comb begin
    hd_pend_d = hd_pend_q;
    vd_pend_d = vd_pend_q;
    sh_pend_d = sh_pend_q;
    hd_live_d = hd_live_q;
    vd_live_d = vd_live_q;
    sh_live_d = sh_live_q;
    hd_v_d    = hd_v_q;
    vd_v_d    = vd_v_q;
    sh_v_d    = sh_v_q;
    pwr_d     = pwr_q;

    if (acc_ctl_i) pwr_d = pwr_new_i;

    if (hd_commit_i && hd_v_q) begin
      hd_live_d = hd_pend_q;
      hd_v_d    = 1'b0;
    end
    if (hd_commit_i && sh_v_q) begin
      sh_live_d = sh_pend_q;
      sh_v_d    = 1'b0;
    end
    if (vd_commit_i && vd_v_q) begin
      vd_live_d = vd_pend_q;
      vd_v_d    = 1'b0;
    end

    if (take_ctl) begin
      hd_pend_d = hd_new_i;
      vd_pend_d = vd_new_i;
      hd_v_d    = 1'b1;
      vd_v_d    = 1'b1;
    end
    if (take_shut) begin
      sh_pend_d = shut_new_i;
      sh_v_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_pend_q <= HD_CTL_RST;
      hd_live_q <= HD_CTL_RST;
      vd_pend_q <= '0;
      vd_live_q <= '0;
      sh_pend_q <= '0;
      sh_live_q <= '0;
      hd_v_q    <= 1'b0;
      vd_v_q    <= 1'b0;
      sh_v_q    <= 1'b0;
      pwr_q     <= PWR_RUN0;
    end else begin
      hd_pend_q <= hd_pend_d;
      hd_live_q <= hd_live_d;
      vd_pend_q <= vd_pend_d;
      vd_live_q <= vd_live_d;
      sh_pend_q <= sh_pend_d;
      sh_live_q <= sh_live_d;
      hd_v_q    <= hd_v_d;
      vd_v_q    <= vd_v_d;
      sh_v_q    <= sh_v_d;
      pwr_q     <= pwr_d;
    end
  end

  assign hd_live_o   = hd_live_q;
  assign vd_live_o   = vd_live_q;
  assign shut_live_o = sh_live_q;
  assign pwr_o       = pwr_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import slr_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int CODE_W  = 8,
  parameter logic [CODE_W-1:0] CHIP_CODE = 8'h81
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sdat_i,
  input  logic        sclk_i,
  input  logic        sen_i,
  input  logic        hd_i,
  input  logic        vd_i,
  input  logic        rdline_i,
  input  logic        freeze_i,
  output logic [2:0]  drv_mode_o,
  output logic        shut_en_o,
  output logic        rd_supp_o,
  output logic        pal_sel_o,
  output logic        wide_ob_o,
  output logic        exp_sel_o,
  output logic [1:0]  ob_pat_o,
  output logic [1:0]  adc_phase_o,
  output logic        sleep_o,
  output logic        standby_o,
  output logic [9:0]  shut_vcnt_o,
  output logic [11:0] shut_hcnt_o,
  output logic [9:0]  shut_hpos_o
);
  localparam int EDGE_N  = 4;
  localparam int E_SCLK  = 0;
  localparam int E_SEN   = 1;
  localparam int E_HD    = 2;
  localparam int E_VD    = 3;
  localparam logic [EDGE_N-1:0] EDGE_RST = EDGE_N'(1 << E_SEN);

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [EDGE_N-1:0]  rise, fall;
  logic               tick, word_full, is_ctl, is_shut;
  logic               acc_ctl, acc_shut, hd_commit, vd_commit;
  logic [FRAME_W-1:0] word;
  hd_ctl_t            hd_new, hd_live;
  vd_ctl_t            vd_new, vd_live;
  shut_t              sh_new, sh_live;
  pwr_t               pwr_new, pwr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  slr_edge_det #(.N(EDGE_N), .RST_VAL(EDGE_RST)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .sig_i  ({vd_i, hd_i, sen_i, sclk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign tick = rise[E_SCLK] & ~sen_i;

  slr_shift_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_i (tick),
    .sen_i  (sen_i),
    .din_i  (sdat_i),
    .word_o (word),
    .full_o (word_full)
  );

  slr_word_decode #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .CHIP_CODE(CHIP_CODE)) u_dec (
    .word_i    (word),
    .is_ctl_o  (is_ctl),
    .is_shut_o (is_shut),
    .hd_o      (hd_new),
    .vd_o      (vd_new),
    .shut_o    (sh_new),
    .pwr_o     (pwr_new)
  );

  assign acc_ctl   = rise[E_SEN] & word_full & is_ctl;
  assign acc_shut  = rise[E_SEN] & word_full & is_shut;
  assign hd_commit = fall[E_HD] & rdline_i & ~freeze_i;
  assign vd_commit = fall[E_VD] & ~freeze_i;

  slr_reg_bank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .acc_ctl_i   (acc_ctl),
    .acc_shut_i  (acc_shut),
    .hd_new_i    (hd_new),
    .vd_new_i    (vd_new),
    .shut_new_i  (sh_new),
    .pwr_new_i   (pwr_new),
    .hd_commit_i (hd_commit),
    .vd_commit_i (vd_commit),
    .hd_live_o   (hd_live),
    .vd_live_o   (vd_live),
    .shut_live_o (sh_live),
    .pwr_o       (pwr)
  );

  assign drv_mode_o  = vd_live.mode;
  assign pal_sel_o   = vd_live.pal;
  assign shut_en_o   = hd_live.shen;
  assign rd_supp_o   = hd_live.rds;
  assign wide_ob_o   = hd_live.wob;
  assign exp_sel_o   = hd_live.expsel;
  assign ob_pat_o    = hd_live.obp;
  assign adc_phase_o = hd_live.adc;
  assign sleep_o     = (pwr == PWR_SLEEP);
  assign standby_o   = (pwr == PWR_STBY);
  assign shut_vcnt_o = sh_live.vcnt;
  assign shut_hcnt_o = sh_live.hcnt;
  assign shut_hpos_o = sh_live.hpos;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sen_i,
  input logic        hd_i,
  input logic        vd_i,
  input logic        rdline_i,
  input logic        freeze_i,
  input logic [2:0]  drv_mode_o,
  input logic [1:0]  adc_phase_o,
  input logic [11:0] shut_hcnt_o,
  input logic        sleep_o,
  input logic        standby_o
);
  logic sen_q, hd_q, vd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_q <= 1'b1;
      hd_q  <= 1'b0;
      vd_q  <= 1'b0;
    end else begin
      sen_q <= sen_i;
      hd_q  <= hd_i;
      vd_q  <= vd_i;
    end
  end

  AST_ADC_AT_READOUT_HD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(adc_phase_o) |-> $past(hd_q && !hd_i && rdline_i && !freeze_i));  // R5
  AST_SHUT_AT_READOUT_HD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shut_hcnt_o) |-> $past(hd_q && !hd_i && rdline_i && !freeze_i));  // R11
  AST_MODE_AT_VD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drv_mode_o) |-> $past(vd_q && !vd_i && !freeze_i));  // R6
  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(freeze_i) |-> ($stable(drv_mode_o) && $stable(adc_phase_o) && $stable(shut_hcnt_o)));  // R7
  AST_PWR_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({sleep_o, standby_o}) |-> $past(sen_i && !sen_q));  // R8
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sen_i       (sen_i),
  .hd_i        (hd_i),
  .vd_i        (vd_i),
  .rdline_i    (rdline_i),
  .freeze_i    (freeze_i),
  .drv_mode_o  (drv_mode_o),
  .adc_phase_o (adc_phase_o),
  .shut_hcnt_o (shut_hcnt_o),
  .sleep_o     (sleep_o),
  .standby_o   (standby_o)
);

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, sdat, sclk, sen, hd, vd, rdline, freeze;
  logic [2:0]  drv_mode;
  logic        shut_en, rd_supp, pal_sel, wide_ob, exp_sel, sleep, standby;
  logic [1:0]  ob_pat, adc_phase;
  logic [9:0]  vcnt, hpos;
  logic [11:0] hcnt;

  int checks = 0;
  int fails  = 0;

  // bench model of live, pending and power state
  logic [2:0]  m_mode, p_mode;
  logic        m_shen, m_rds, m_pal, m_wob, m_exp, p_shen, p_rds, p_pal, p_wob, p_exp;
  logic [1:0]  m_obp, m_adc, p_obp, p_adc, m_pwr;
  logic [9:0]  m_v, m_p, p_v, p_p;
  logic [11:0] m_h, p_h;
  logic        p_hd_v, p_vd_v, p_sh_v;

  always #(CLK_P/2) clk = ~clk;

  serial_cfg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdat_i(sdat), .sclk_i(sclk), .sen_i(sen),
    .hd_i(hd), .vd_i(vd), .rdline_i(rdline), .freeze_i(freeze),
    .drv_mode_o(drv_mode), .shut_en_o(shut_en), .rd_supp_o(rd_supp),
    .pal_sel_o(pal_sel), .wide_ob_o(wide_ob), .exp_sel_o(exp_sel),
    .ob_pat_o(ob_pat), .adc_phase_o(adc_phase), .sleep_o(sleep),
    .standby_o(standby), .shut_vcnt_o(vcnt), .shut_hcnt_o(hcnt),
    .shut_hpos_o(hpos)
  );

  function automatic logic [45:0] act_vec();
    return {drv_mode, shut_en, rd_supp, pal_sel, wide_ob, exp_sel, ob_pat,
            adc_phase, sleep, standby, vcnt, hcnt, hpos};
  endfunction

  function automatic logic [45:0] exp_vec();
    return {m_mode, m_shen, m_rds, m_pal, m_wob, m_exp, m_obp, m_adc,
            (m_pwr == 2'b01), (m_pwr == 2'b11), m_v, m_h, m_p};
  endfunction

  task automatic chk(input string tag);
    checks++;
    if (act_vec() !== exp_vec()) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_vec(), exp_vec());
    end
  endtask

  function automatic logic [47:0] mk_ctl(input logic [2:0] md, input logic se, rs, pl, wb, ex,
                                         input logic [1:0] ob, ad, pw);
    logic [47:0] w = '0;
    w[7:0] = 8'h81; w[9:8] = 2'b00; w[12:10] = md; w[13] = se; w[14] = rs;
    w[17] = pl; w[32] = wb; w[33] = ex; w[35:34] = ob; w[37:36] = ad; w[39:38] = pw;
    w[21] = 1'b1; w[45] = 1'b1;  // unused bits set on purpose
    return w;
  endfunction

  function automatic logic [47:0] mk_sh(input logic [9:0] v, input logic [11:0] h, input logic [9:0] p);
    logic [47:0] w = '0;
    w[7:0] = 8'h81; w[9:8] = 2'b01; w[19:10] = v; w[31:20] = h; w[41:32] = p; w[47] = 1'b1;
    return w;
  endfunction

  task automatic model_word(input logic [47:0] w, input int nb);
    logic was_stby = (m_pwr == 2'b11);
    if (nb == 48 && w[7:0] == 8'h81) begin
      if (w[9:8] == 2'b00) begin
        m_pwr = w[39:38];
        if (!was_stby) begin
          p_mode = w[12:10]; p_shen = w[13]; p_rds = w[14]; p_pal = w[17];
          p_wob = w[32]; p_exp = w[33]; p_obp = w[35:34]; p_adc = w[37:36];
          p_hd_v = 1'b1; p_vd_v = 1'b1;
        end
      end else if (w[9:8] == 2'b01 && !was_stby) begin
        p_v = w[19:10]; p_h = w[31:20]; p_p = w[41:32]; p_sh_v = 1'b1;
      end
    end
  endtask

  task automatic send(input logic [47:0] w, input int nb);
    sen = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdat = (i < 48) ? w[i] : 1'b0;
      sclk = 1'b0;
      @(negedge clk);
      sclk = 1'b1;
      @(negedge clk);
    end
    sclk = 1'b0;
    @(negedge clk);
    sen = 1'b1;
    repeat (2) @(negedge clk);
    model_word(w, nb);
  endtask

  task automatic hd_pulse();
    hd = 1'b1;
    repeat (2) @(negedge clk);
    hd = 1'b0;
    repeat (2) @(negedge clk);
    if (rdline && !freeze) begin
      if (p_hd_v) begin
        m_shen = p_shen; m_rds = p_rds; m_wob = p_wob; m_exp = p_exp;
        m_obp = p_obp; m_adc = p_adc; p_hd_v = 1'b0;
      end
      if (p_sh_v) begin
        m_v = p_v; m_h = p_h; m_p = p_p; p_sh_v = 1'b0;
      end
    end
  endtask

  task automatic vd_pulse();
    vd = 1'b1;
    repeat (2) @(negedge clk);
    vd = 1'b0;
    repeat (2) @(negedge clk);
    if (!freeze && p_vd_v) begin
      m_mode = p_mode; m_pal = p_pal; p_vd_v = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] w;
    rst_n = 1'b0; sdat = 1'b0; sclk = 1'b0; sen = 1'b1;
    hd = 1'b0; vd = 1'b0; rdline = 1'b0; freeze = 1'b0;
    m_mode = '0; m_shen = 0; m_rds = 0; m_pal = 0; m_wob = 0; m_exp = 0;
    m_obp = '0; m_adc = 2'b01; m_pwr = '0; m_v = '0; m_h = '0; m_p = '0;
    p_mode = '0; p_shen = 0; p_rds = 0; p_pal = 0; p_wob = 0; p_exp = 0;
    p_obp = '0; p_adc = 2'b01; p_v = '0; p_h = '0; p_p = '0;
    p_hd_v = 0; p_vd_v = 0; p_sh_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset values, adc phase 90 deg");

    // R4 R5 R6: sweep of control words over every drive mode
    for (int i = 0; i < 8; i++) begin
      logic [2:0] iv = 3'(i);
      w = mk_ctl(iv, iv[0], iv[1], iv[2], ~iv[0], iv[1] ^ iv[2], iv[1:0],
                 2'(i + 2), iv[2] ? 2'b10 : 2'b00);
      send(w, 48);
      chk("R4 accepted word not yet live");
      rdline = 1'b0;
      hd_pulse();
      chk("R5 hd edge off readout line");
      rdline = 1'b1;
      hd_pulse();
      chk("R5 hd edge on readout line");
      vd_pulse();
      chk("R6 vd edge commits mode");
    end

    // R11: shutter field sweep
    for (int i = 0; i < 6; i++) begin
      send(mk_sh(10'(i * 205), 12'(4095 - i * 819), 10'(1023 - i * 200)), 48);
      chk("R11 shutter word pending");
      hd_pulse();
      chk("R11 shutter word committed");
    end

    // R2: every single-bit corruption of the chip code
    for (int b = 0; b < 8; b++) begin
      w = mk_ctl(3'd5, 1, 1, 1, 1, 1, 2'b11, 2'b11, 2'b01) ^ (48'd1 << b);
      send(w, 48);
      hd_pulse();
      vd_pulse();
      chk("R2 bad chip code ignored");
    end

    // R3: test categories ignored
    for (int c = 2; c < 4; c++) begin
      w = mk_ctl(3'd6, 1, 0, 1, 0, 1, 2'b10, 2'b00, 2'b01);
      w[9:8] = 2'(c);
      send(w, 48);
      hd_pulse();
      vd_pulse();
      chk("R3 category 1x ignored");
    end

    // R1: wrong lengths
    send(mk_ctl(3'd3, 1, 1, 0, 0, 1, 2'b01, 2'b10, 2'b01), 47);
    hd_pulse(); vd_pulse();
    chk("R1 47-bit word ignored");
    send(mk_ctl(3'd3, 1, 1, 0, 0, 1, 2'b01, 2'b10, 2'b01), 49);
    hd_pulse(); vd_pulse();
    chk("R1 49-bit word ignored");

    // R3: repeated category overwrites
    send(mk_ctl(3'd1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00), 48);
    send(mk_ctl(3'd2, 1, 0, 1, 1, 0, 2'b11, 2'b01, 2'b00), 48);
    hd_pulse(); vd_pulse();
    chk("R3 second control word wins");
    send(mk_sh(10'd7, 12'd9, 10'd11), 48);
    send(mk_sh(10'd300, 12'd2047, 10'd512), 48);
    hd_pulse();
    chk("R3 second shutter word wins");

    // R7: freeze
    send(mk_ctl(3'd4, 0, 1, 0, 0, 1, 2'b01, 2'b11, 2'b00), 48);
    send(mk_sh(10'd1, 12'd2, 10'd3), 48);
    freeze = 1'b1;
    hd_pulse(); vd_pulse();
    chk("R7 frozen edges commit nothing");
    freeze = 1'b0;
    hd_pulse(); vd_pulse();
    chk("R7 pending committed after freeze");

    // R8: power-state encodings
    for (int s = 0; s < 4; s++) begin
      send(mk_ctl(3'(s), 0, 0, 0, 0, 0, 2'(s), 2'(s), 2'(s)), 48);
      chk("R8 power state at strobe");
    end
    hd_pulse(); vd_pulse();
    chk("R8 fields of standby-entry word commit");

    // R9: standby loading
    send(mk_sh(10'd999, 12'd1234, 10'd555), 48);
    hd_pulse();
    chk("R9 shutter word ignored in standby");
    send(mk_ctl(3'd7, 1, 1, 1, 1, 1, 2'b11, 2'b10, 2'b00), 48);
    chk("R9 standby exit via control word");
    hd_pulse(); vd_pulse();
    chk("R9 other fields untouched by standby word");

    summary();
    $finish;
  end
endmodule